// File: doc/BRIEF.md
# Shared-Memory Bank Conflict Scheduler

This block examines one warp's shared-memory request and decides when each of its accesses may run. Each lane gives a byte address. An active mask selects the lanes that take part, and a flag marks the request as atomic. The block walks the lanes one per cycle. Lanes that carry an identical address are folded into one access with a combined lane mask. Every distinct access gets an issue slot, called its order. Accesses that share an order use different banks, so they can be served in the same cycle.

The warp is cut into equal parts that are handled one after another. A lane never joins an access created in an earlier part, and no access in a later part can take a slot below that part's first lane index. An address that two or more lanes share is a broadcast, and each broadcast gets a slot of its own above the warp size.

After the last lane, the block sends the accesses out on a valid/ready stream, lowest order first. It then raises a one-cycle completion flag. The block does not hold data, banks or a writeback path. It only does address analysis and slot assignment.

Top module: `smb_conflict_sched`

## Requirements
- R1: After reset, `out_valid` and `done` are low.
- R2: An inactive lane takes no part. It is never set in any `out_mask`, and a request with no active lanes produces no entry at all, only `done`.
- R3: The bank of an access is its word address (byte address divided by 4) modulo the bank count, which means bits [5:2] with 16 banks. Within one part, distinct accesses to the same bank get consecutive orders. Accesses to distinct banks can share an order.
- R4: A new access reads its bank's slot counter and raises it to the first lane index of the current part (part k starts at lane 16·k) if the counter is lower. It takes that value as its order, and the counter then advances by one.
- R5: In a non-atomic request, a lane whose byte address equals an access already created in the same part joins that access, and its bit is set in the mask. That access's order is then replaced by the next broadcast slot: 33, 34, … and so on, one counter for the whole warp.
- R6: Lanes in different parts are never merged, even when their addresses are equal.
- R7: In an atomic request, every active lane produces its own access and no merge takes place.
- R8: Entries leave in ascending order. Entries with equal order leave in the sequence in which they were created.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr`, `out_order` and `out_mask` hold their values.
- R10: `done` is high for exactly one cycle after the last entry has been accepted. No entry is offered after it.
- R11: The request is captured when `start` is accepted while idle. A `start` pulse or an input change during processing has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a new request when idle |
| req_atomic | input | 1 | Request is atomic: no merging |
| req_active | input | 32 | Per-lane active mask |
| req_addr | input | 1024 | Lane byte addresses, lane i at bits [32·i+31:32·i] |
| out_valid | output | 1 | An access entry is offered |
| out_ready | input | 1 | Consumer accepts the offered entry |
| out_addr | output | 32 | Byte address of the access |
| out_order | output | 6 | Issue slot of the access |
| out_mask | output | 32 | Lanes served by the access |
| done | output | 1 | One-cycle pulse after the final entry |

## Verification
In a single scan cycle, the lane that closes a warp part can merge into an existing access or allocate a new one while the next part's merge window and bank floor are being set. Both actions then affect the same table and counters at one clock edge. The bench sets this up by giving identical addresses to lanes on both sides of the part boundary, and by giving them random small address pools. It judges the result by comparing every emitted entry's mask, address and order with a bench model. In that model, lane 16 can never join a part-0 access, and no part-1 order falls below 16.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_EMIT,
        ST_FIN
    } sched_state_e;

    function automatic int unsigned part_first_lane(int unsigned lane, int unsigned part_lanes);
        return (lane / part_lanes) * part_lanes;
    endfunction

    function automatic bit part_last_lane(int unsigned lane, int unsigned part_lanes);
        return (lane % part_lanes) == (part_lanes - 1);
    endfunction

endpackage

// File: rtl/smb_match_find.sv
module smb_match_find #(
    parameter int unsigned LANES  = 32,
    parameter int unsigned ADDR_W = 32
) (
    input  logic                          en,
    input  logic [LANES-1:0][ADDR_W-1:0]  tbl_addr,
    input  logic [$clog2(LANES+1)-1:0]    lo,
    input  logic [$clog2(LANES+1)-1:0]    hi,
    input  logic [ADDR_W-1:0]             probe,
    output logic                          hit,
    output logic [$clog2(LANES)-1:0]      hit_idx
);
    localparam int unsigned IDX_W  = $clog2(LANES + 1);
    localparam int unsigned LANE_W = $clog2(LANES);

    logic [LANES-1:0] eq;

    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign eq[g] = en && (IDX_W'(g) >= lo) && (IDX_W'(g) < hi)
                       && (tbl_addr[g] == probe);
    end

    always_comb begin
        hit     = |eq;
        hit_idx = '0;
        for (int i = int'(LANES) - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = LANE_W'(i);
        end
    end

endmodule

// File: rtl/smb_bank_slots.sv
module smb_bank_slots #(
    parameter int unsigned LANES      = 32,
    parameter int unsigned NBANKS     = 16,
    parameter int unsigned PARTS      = 2,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned WORD_BYTES = 4,
    parameter int unsigned ORDER_W    = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               alloc,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ORDER_W-1:0] part_base,
    output logic [ORDER_W-1:0] slot
);
    localparam int unsigned BANK_W     = $clog2(NBANKS);
    localparam int unsigned WORD_SH    = $clog2(WORD_BYTES);
    localparam int unsigned PART_LANES = LANES / PARTS;

    logic [BANK_W-1:0]                bank;
    logic [NBANKS-1:0][ORDER_W-1:0]   cnt_q;

    assign bank = addr[WORD_SH +: BANK_W];
    assign slot = (cnt_q[bank] < part_base) ? part_base : cnt_q[bank];

    always_ff @(posedge clk) begin
        for (int b = 0; b < int'(NBANKS); b++) begin
            if (rst || clear) begin
                cnt_q[b] <= '0;
            end else if (alloc && (bank == BANK_W'(b))) begin
                cnt_q[b] <= slot + 1'b1;
            end
        end
    end

    // R4: a freshly given slot stays inside the window of the current part
    p_slot_window_r4: assert property (@(posedge clk) disable iff (rst)
        alloc |-> (slot >= part_base) && (slot < part_base + ORDER_W'(PART_LANES)));

endmodule

// File: rtl/smb_emit_pick.sv
module smb_emit_pick #(
    parameter int unsigned LANES   = 32,
    parameter int unsigned ORDER_W = 6
) (
    input  logic [LANES-1:0][ORDER_W-1:0] tbl_order,
    input  logic [LANES-1:0]              live,
    input  logic [ORDER_W-1:0]            cur,
    output logic                          found,
    output logic [$clog2(LANES)-1:0]      idx
);
    localparam int unsigned LANE_W = $clog2(LANES);

    logic [LANES-1:0] eq;

    for (genvar g = 0; g < LANES; g++) begin : g_sel
        assign eq[g] = live[g] && (tbl_order[g] == cur);
    end

    always_comb begin
        found = |eq;
        idx   = '0;
        for (int i = int'(LANES) - 1; i >= 0; i--) begin
            if (eq[i]) idx = LANE_W'(i);
        end
    end

endmodule

// File: rtl/smb_conflict_sched.sv
module smb_conflict_sched
    import smb_pkg::*;
#(
    parameter int unsigned LANES      = 32,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned NBANKS     = 16,
    parameter int unsigned PARTS      = 2,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic                          req_atomic,
    input  logic [LANES-1:0]              req_active,
    input  logic [LANES*ADDR_W-1:0]       req_addr,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [ADDR_W-1:0]             out_addr,
    output logic [$clog2(2*LANES)-1:0]    out_order,
    output logic [LANES-1:0]              out_mask,
    output logic                          done
);
    localparam int unsigned PART_LANES = LANES / PARTS;
    localparam int unsigned LANE_W     = $clog2(LANES);
    localparam int unsigned IDX_W      = $clog2(LANES + 1);
    localparam int unsigned ORDER_W    = $clog2(2 * LANES);

    sched_state_e                   state_q;
    logic [LANE_W-1:0]              lane_q;
    logic [IDX_W-1:0]               count_q, pbase_q, nemit_q;
    logic [ORDER_W-1:0]             bcast_q, scan_v_q, last_q;
    logic [LANES-1:0][ADDR_W-1:0]   cap_addr, tbl_addr;
    logic [LANES-1:0][ORDER_W-1:0]  tbl_order;
    logic [LANES-1:0][LANES-1:0]    tbl_mask;
    logic [LANES-1:0]               cap_active, emitted_q, live;
    logic                           cap_atomic;

    logic                           scan_on, lane_on, hit, alloc, pick_found;
    logic                           handshake, part_end, accept;
    logic [LANE_W-1:0]              hit_idx, pick_idx, tail_idx;
    logic [ADDR_W-1:0]              lane_addr;
    logic [ORDER_W-1:0]             slot, part_first;
    logic [LANES-1:0]               lane_bit;

    assign accept     = (state_q == ST_IDLE) && start;
    assign scan_on    = (state_q == ST_SCAN);
    assign lane_addr  = cap_addr[lane_q];
    assign lane_on    = scan_on && cap_active[lane_q];
    assign alloc      = lane_on && !hit;
    assign lane_bit   = LANES'(1) << lane_q;
    assign part_first = ORDER_W'(part_first_lane(32'(lane_q), PART_LANES));
    assign part_end   = part_last_lane(32'(lane_q), PART_LANES);
    assign tail_idx   = count_q[LANE_W-1:0];

    smb_match_find #(.LANES(LANES), .ADDR_W(ADDR_W)) u_match (
        .en      (lane_on && !cap_atomic),
        .tbl_addr(tbl_addr),
        .lo      (pbase_q),
        .hi      (count_q),
        .probe   (lane_addr),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    smb_bank_slots #(
        .LANES(LANES), .NBANKS(NBANKS), .PARTS(PARTS),
        .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .ORDER_W(ORDER_W)
    ) u_banks (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .alloc    (alloc),
        .addr     (lane_addr),
        .part_base(part_first),
        .slot     (slot)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_live
        assign live[g] = (IDX_W'(g) < count_q) && !emitted_q[g];
    end

    smb_emit_pick #(.LANES(LANES), .ORDER_W(ORDER_W)) u_pick (
        .tbl_order(tbl_order),
        .live     (live),
        .cur      (scan_v_q),
        .found    (pick_found),
        .idx      (pick_idx)
    );

    assign out_valid = (state_q == ST_EMIT) && pick_found;
    assign out_addr  = tbl_addr[pick_idx];
    assign out_order = tbl_order[pick_idx];
    assign out_mask  = tbl_mask[pick_idx];
    assign handshake = out_valid && out_ready;
    assign done      = (state_q == ST_FIN);

    // control path
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            lane_q     <= '0;
            count_q    <= '0;
            pbase_q    <= '0;
            nemit_q    <= '0;
            bcast_q    <= ORDER_W'(LANES);
            scan_v_q   <= '0;
            last_q     <= '0;
            emitted_q  <= '0;
            cap_active <= '0;
            cap_atomic <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q    <= ST_SCAN;
                    lane_q     <= '0;
                    count_q    <= '0;
                    pbase_q    <= '0;
                    nemit_q    <= '0;
                    bcast_q    <= ORDER_W'(LANES);
                    scan_v_q   <= '0;
                    last_q     <= '0;
                    emitted_q  <= '0;
                    cap_active <= req_active;
                    cap_atomic <= req_atomic;
                end
                ST_SCAN: begin
                    lane_q <= lane_q + 1'b1;
                    if (alloc)    count_q <= count_q + 1'b1;
                    else if (hit) bcast_q <= bcast_q + 1'b1;
                    if (part_end) pbase_q <= count_q + IDX_W'(alloc);
                    if (lane_q == LANE_W'(LANES - 1)) state_q <= ST_EMIT;
                end
                ST_EMIT: begin
                    if (nemit_q == count_q) begin
                        state_q <= ST_FIN;
                    end else if (handshake) begin
                        emitted_q[pick_idx] <= 1'b1;
                        nemit_q             <= nemit_q + 1'b1;
                        last_q              <= out_order;
                    end else if (!pick_found) begin
                        scan_v_q <= scan_v_q + 1'b1;
                    end
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // request capture and access table
    always_ff @(posedge clk) begin
        if (accept) cap_addr <= req_addr;
        if (alloc) begin
            tbl_addr[tail_idx]  <= lane_addr;
            tbl_order[tail_idx] <= slot;
            tbl_mask[tail_idx]  <= lane_bit;
        end else if (hit) begin
            tbl_mask[hit_idx]  <= tbl_mask[hit_idx] | lane_bit;
            tbl_order[hit_idx] <= bcast_q + 1'b1;
        end
    end

    // R9: an offered entry stays put until taken
    p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                       && $stable(out_order) && $stable(out_mask)));

    // R8: accepted orders never go down within one request
    p_order_rise_r8: assert property (@(posedge clk) disable iff (rst)
        handshake |-> (out_order >= last_q));

    // R10: completion is a single pulse with nothing offered next
    p_done_once_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !out_valid));

    // R7: atomic requests never find a merge partner
    p_atomic_alone_r7: assert property (@(posedge clk) disable iff (rst)
        (scan_on && cap_atomic) |-> !hit);

    // R2: an offered mask is non-empty and only covers active lanes
    p_mask_active_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_mask != '0) && ((out_mask & ~cap_active) == '0)));

endmodule

// File: tb/smb_conflict_sched_tb_top.sv
module smb_conflict_sched_tb_top;

    localparam int LANES  = 32;
    localparam int ADDR_W = 32;
    localparam int NBANKS = 16;
    localparam int PARTS  = 2;
    localparam int PL     = LANES / PARTS;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     start = 1'b0;
    logic                     req_atomic = 1'b0;
    logic [LANES-1:0]         req_active = '0;
    logic [LANES*ADDR_W-1:0]  req_addr = '0;
    logic                     out_ready = 1'b0;
    logic                     out_valid;
    logic [ADDR_W-1:0]        out_addr;
    logic [5:0]               out_order;
    logic [LANES-1:0]         out_mask;
    logic                     done;

    always #10 clk = ~clk;

    smb_conflict_sched dut_i (
        .clk(clk), .rst(rst), .start(start), .req_atomic(req_atomic),
        .req_active(req_active), .req_addr(req_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_order(out_order), .out_mask(out_mask), .done(done)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit hung = 0;

    logic [ADDR_W-1:0] lane_a [LANES];
    logic [ADDR_W-1:0] e_addr [LANES];
    int                e_order [LANES];
    logic [LANES-1:0]  e_mask [LANES];
    int                e_n;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // expected accesses, derived from the requirements
    task automatic build_model(input logic [LANES-1:0] act, input bit atom);
        int cnt [NBANKS];
        int bc, pb, f, b, first;
        logic [ADDR_W-1:0] ta;
        int to;
        logic [LANES-1:0] tm;
        foreach (cnt[k]) cnt[k] = 0;
        bc = LANES; pb = 0; e_n = 0;
        for (int l = 0; l < LANES; l++) begin
            if (l % PL == 0) pb = e_n;
            if (!act[l]) continue;
            f = -1;
            if (!atom) begin
                for (int j = pb; j < e_n; j++) begin
                    if (e_addr[j] == lane_a[l]) begin f = j; break; end
                end
            end
            if (f >= 0) begin
                e_mask[f][l] = 1'b1;
                bc++;
                e_order[f] = bc;
            end else begin
                b = int'((lane_a[l] >> 2) % NBANKS);
                first = (l / PL) * PL;
                if (cnt[b] < first) cnt[b] = first;
                e_order[e_n] = cnt[b];
                cnt[b]++;
                e_addr[e_n] = lane_a[l];
                e_mask[e_n] = '0;
                e_mask[e_n][l] = 1'b1;
                e_n++;
            end
        end
        for (int i = 1; i < e_n; i++) begin
            int j;
            ta = e_addr[i]; to = e_order[i]; tm = e_mask[i];
            j = i - 1;
            while (j >= 0 && e_order[j] > to) begin
                e_addr[j+1] = e_addr[j]; e_order[j+1] = e_order[j]; e_mask[j+1] = e_mask[j];
                j--;
            end
            e_addr[j+1] = ta; e_order[j+1] = to; e_mask[j+1] = tm;
        end
    endtask

    task automatic run_req(input logic [LANES-1:0] act, input bit atom, input string tag,
                           input bit rnd_ready, input bit disturb);
        int got, cyc;
        bit held, dseen;
        logic [ADDR_W-1:0] h_addr;
        logic [5:0] h_order;
        logic [LANES-1:0] h_mask;
        for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = lane_a[l];
        req_active = act;
        req_atomic = atom;
        build_model(act, atom);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 0; cyc = 0; held = 0; dseen = 0;
        while (!dseen && !hung) begin
            if (disturb && cyc == 4) begin
                for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = $urandom;
                req_active = ~act;
                req_atomic = ~atom;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (held) begin
                chk(out_valid && out_addr == h_addr && out_order == h_order && out_mask == h_mask,
                    "R9", "stalled entry held", {out_valid, out_order}, {1'b1, h_order});
            end
            out_ready = rnd_ready ? ($urandom % 3 != 0) : 1'b1;
            held = 0;
            if (out_valid) begin
                if (out_ready) begin
                    if (got < e_n) begin
                        chk(out_order == 6'(e_order[got]), tag, "order", out_order, e_order[got]);
                        chk(out_addr == e_addr[got], tag, "address", out_addr, e_addr[got]);
                        chk(out_mask == e_mask[got], tag, "lane mask", out_mask, e_mask[got]);
                    end else begin
                        chk(1'b0, tag, "extra entry count", got + 1, e_n);
                    end
                    got++;
                end else begin
                    held = 1;
                    h_addr = out_addr; h_order = out_order; h_mask = out_mask;
                end
            end
            if (done) begin
                dseen = 1;
                chk(got == e_n, "R10", "entries before done", got, e_n);
                chk(!out_valid, "R10", "valid with done", out_valid, 0);
            end
            cyc++;
            if (cyc > 3000) begin
                hung = 1;
                chk(1'b0, "watchdog", "request never completed", cyc, 0);
            end
            @(negedge clk);
        end
        start = 1'b0;
        out_ready = 1'b0;
        if (dseen && !hung) chk(!done, "R10", "done width", done, 0);
    endtask

    function automatic logic [ADDR_W-1:0] pool_addr();
        return 32'h0000_1000 + ($urandom % 6) * 4 + ($urandom % 3) * 64;
    endfunction

    initial begin
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !done, "R1", "reset outputs", {out_valid, done}, 0);

        // R5: one shared address across the whole warp
        for (int l = 0; l < LANES; l++) lane_a[l] = 32'h0000_0100;
        run_req('1, 1'b0, "R5", 1'b0, 1'b0);

        // R3: stride of one word, all banks distinct
        for (int l = 0; l < LANES; l++) lane_a[l] = 32'(l * 4);
        run_req('1, 1'b0, "R3", 1'b0, 1'b0);

        // R4: every lane in bank 0, part-1 slots floored at 16
        for (int l = 0; l < LANES; l++) lane_a[l] = 32'(l * 64);
        run_req('1, 1'b0, "R4", 1'b1, 1'b0);

        // R7: atomic with one shared address
        for (int l = 0; l < LANES; l++) lane_a[l] = 32'h0000_0200;
        run_req('1, 1'b1, "R7", 1'b0, 1'b0);

        // R6: lane l and lane l+16 share an address
        for (int l = 0; l < LANES; l++) lane_a[l] = 32'((l % PL) * 4 + 32'h300);
        run_req('1, 1'b0, "R6", 1'b0, 1'b0);

        // R2: no active lanes, then a sparse mask
        run_req('0, 1'b0, "R2", 1'b0, 1'b0);
        for (int l = 0; l < LANES; l++) lane_a[l] = pool_addr();
        run_req(32'hA5A5_0F0F, 1'b0, "R2", 1'b1, 1'b0);

        // R11: start and input changes during processing are ignored
        for (int l = 0; l < LANES; l++) lane_a[l] = pool_addr();
        run_req(32'hFFFF_00FF, 1'b0, "R11", 1'b1, 1'b1);

        // R8: random mixes with ties and broadcasts, random backpressure
        for (int t = 0; t < 40 && !hung; t++) begin
            logic [LANES-1:0] act;
            for (int l = 0; l < LANES; l++) lane_a[l] = pool_addr();
            act = ($urandom % 3 == 0) ? '1 : LANES'($urandom);
            run_req(act, ($urandom % 5 == 0), "R8", 1'b1, 1'b0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule